// File: doc/BRIEF.md
# Lane Data Descrambler with Enable Override

This block sits in the receive path of one lane of an 8b/10b serial link, after the symbol decoder. Each cycle it may take one decoded symbol: an 8-bit value and a flag that marks it as a control symbol. Data bytes, including idle filler bytes, are XORed with a keystream from a 16-bit linear feedback shift register. Control symbols pass through unchanged, but they steer the register. An alignment (comma) symbol reloads the seed. A skip symbol freezes the register. Every other symbol moves it forward one byte's worth of steps.

Link training normally decides whether descrambling is active. Two override modes replace that decision: one forces descrambling off and the other forces it on. A select input picks one of two keystream bit orderings. The two orderings are not compatible, so both ends of the link must use the same one.

The output is registered, so it comes one cycle after the input. The valid and control flags travel through the same register stage as the data.

Top module: `lnk_descrambler`

## Requirements
- R1: `out_valid`, `out_ctrl` and `out_byte` show the symbol accepted on the previous clock edge. `out_valid` is 1 exactly one cycle after `in_valid` was 1.
- R2: A control symbol (`in_ctrl`=1) leaves with its byte unchanged and with `out_ctrl`=1, whatever the mode.
- R3: The alignment control symbol (`in_ctrl`=1, byte 0xBC) reloads the register with 0xFFFF. The first data byte after it is XORed with the key 0xFF, and the second with 0x17 (ordering A).
- R4: The skip control symbol (`in_ctrl`=1, byte 0x1C) does not move the register. Every other accepted symbol moves it by 8 steps: data bytes, and control symbols other than alignment and skip. This holds even when descrambling is disabled.
- R5: With `mode`=2'b01 (forced off), data bytes leave unchanged.
- R6: With `mode`=2'b10 (forced on), data bytes are descrambled even when `neg_scr_en`=0.
- R7: With `mode`=2'b00 or 2'b11, data bytes are descrambled when `neg_scr_en`=1 and pass unchanged when it is 0.
- R8: With `variant_sel`=0, data bit i is XORed with keystream bit k_i, where k_0 is produced first. With `variant_sel`=1, data bit i is XORed with k_(7-i).
- R9: One step outputs k = s[15] and then sets s to (s<<1) XOR (k ? 0x0039 : 0), within 16 bits. This is the polynomial x^16+x^5+x^4+x^3+1.
- R10: During and just after reset, all outputs are 0 and the register holds 0xFFFF.
- R11: A cycle with `in_valid`=0 leaves the register unchanged and gives `out_valid`=0 on the next cycle.
- R12: A data byte (`in_ctrl`=0) equal to 0xBC or 0x1C is descrambled like any other data byte, and it moves the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A symbol is present this cycle |
| in_ctrl | input | 1 | The symbol is a control symbol |
| in_byte | input | 8 | Decoded symbol value |
| mode | input | 2 | Enable policy: 00/11 follow negotiation, 01 forced off, 10 forced on |
| neg_scr_en | input | 1 | Descrambling enable agreed during training |
| variant_sel | input | 1 | Keystream ordering: 0 = A, 1 = B (bit-reversed) |
| out_valid | output | 1 | Registered symbol valid |
| out_ctrl | output | 1 | Registered control flag |
| out_byte | output | 8 | Descrambled or passed-through value |

## Verification
The bench checks the first two key bytes after an alignment symbol against fixed values worked out by hand. A wrong tap mask, shift direction or seed changes these bytes. It places skip symbols and idle gaps between data bytes; a design that moved the register on these would lose key alignment on every later byte. It also sends data bytes whose value equals the alignment code; a design that treated them as control symbols would reseed the register or leave the byte unscrambled. Finally, it tries the forced modes against the opposite negotiated setting and compares the two orderings on the same key, which catches a swapped policy decode or a missing bit reversal.

// File: rtl/lnkdsc_pkg.sv
package lnkdsc_pkg;

    localparam int BYTE_W = 8;
    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        EN_FOLLOW     = 2'b00,
        EN_FORCE_OFF  = 2'b01,
        EN_FORCE_ON   = 2'b10,
        EN_FOLLOW_ALT = 2'b11
    } en_mode_e;

    typedef enum logic [1:0] {
        SYM_DATA  = 2'd0,
        SYM_ALIGN = 2'd1,
        SYM_SKIP  = 2'd2,
        SYM_OTHER = 2'd3
    } sym_kind_e;

    typedef struct packed {
        logic              is_ctrl;
        logic [BYTE_W-1:0] val;
    } sym_t;

    function automatic logic resolve_enable(input en_mode_e m, input logic neg);
        case (m)
            EN_FORCE_OFF: return 1'b0;
            EN_FORCE_ON:  return 1'b1;
            default:      return neg;
        endcase
    endfunction

endpackage

// File: rtl/desc_classify.sv
module desc_classify
    import lnkdsc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ALIGN_CODE = 8'hBC,
    parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'h1C
) (
    input  sym_t      sym,
    output sym_kind_e kind
);
    always_comb begin
        if (!sym.is_ctrl)                kind = SYM_DATA;
        else if (sym.val == ALIGN_CODE)  kind = SYM_ALIGN;
        else if (sym.val == SKIP_CODE)   kind = SYM_SKIP;
        else                             kind = SYM_OTHER;
    end
endmodule

// File: rtl/desc_lfsr.sv
module desc_lfsr #(
    parameter int              W     = 16,
    parameter int              STEPS = 8,
    parameter logic [W-1:0]    TAPS  = 16'h0039,
    parameter logic [W-1:0]    SEED  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_seed,
    input  logic             advance,
    output logic [W-1:0]     state_q,
    output logic [STEPS-1:0] key
);
    logic [W-1:0] chain [0:STEPS];

    assign chain[0] = state_q;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        assign key[i]      = chain[i][W-1];
        assign chain[i+1]  = {chain[i][W-2:0], 1'b0} ^ (chain[i][W-1] ? TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)            state_q <= SEED;
        else if (load_seed) state_q <= SEED;
        else if (advance)   state_q <= chain[STEPS];
    end
endmodule

// File: rtl/desc_mask.sv
module desc_mask #(
    parameter int N = 8
) (
    input  logic [N-1:0] din,
    input  logic [N-1:0] key,
    input  logic         reverse,
    input  logic         enable,
    output logic [N-1:0] dout
);
    logic [N-1:0] ordered;

    for (genvar i = 0; i < N; i++) begin : g_ord
        assign ordered[i] = reverse ? key[N-1-i] : key[i];
    end

    assign dout = enable ? (din ^ ordered) : din;
endmodule

// File: rtl/lnk_descrambler.sv
module lnk_descrambler
    import lnkdsc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] TAPS       = 16'h0039,
    parameter logic [LFSR_W-1:0] SEED       = 16'hFFFF,
    parameter logic [BYTE_W-1:0] ALIGN_CODE = 8'hBC,
    parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [1:0]        mode,
    input  logic              neg_scr_en,
    input  logic              variant_sel,
    output logic              out_valid,
    output logic              out_ctrl,
    output logic [BYTE_W-1:0] out_byte
);
    sym_t              sym_in;
    sym_kind_e         kind;
    logic              scr_en;
    logic              do_xor;
    logic              load_seed;
    logic              advance;
    logic [LFSR_W-1:0] lfsr_q;
    logic [BYTE_W-1:0] key;
    logic [BYTE_W-1:0] masked;

    assign sym_in = '{is_ctrl: in_ctrl, val: in_byte};

    desc_classify #(
        .ALIGN_CODE (ALIGN_CODE),
        .SKIP_CODE  (SKIP_CODE)
    ) u_cls (
        .sym  (sym_in),
        .kind (kind)
    );

    assign scr_en    = resolve_enable(en_mode_e'(mode), neg_scr_en);
    assign do_xor    = scr_en && (kind == SYM_DATA);
    assign load_seed = in_valid && (kind == SYM_ALIGN);
    assign advance   = in_valid && (kind != SYM_SKIP) && (kind != SYM_ALIGN);

    desc_lfsr #(
        .W     (LFSR_W),
        .STEPS (BYTE_W),
        .TAPS  (TAPS),
        .SEED  (SEED)
    ) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .load_seed (load_seed),
        .advance   (advance),
        .state_q   (lfsr_q),
        .key       (key)
    );

    desc_mask #(
        .N (BYTE_W)
    ) u_mask (
        .din     (in_byte),
        .key     (key),
        .reverse (variant_sel),
        .enable  (do_xor),
        .dout    (masked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_ctrl  <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= in_valid;
            out_ctrl  <= in_valid && in_ctrl;
            out_byte  <= in_valid ? masked : '0;
        end
    end
endmodule

// File: rtl/lnk_descrambler_chk.sv
module lnk_descrambler_chk
    import lnkdsc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED       = 16'hFFFF,
    parameter logic [BYTE_W-1:0] ALIGN_CODE = 8'hBC,
    parameter logic [BYTE_W-1:0] SKIP_CODE  = 8'h1C
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ctrl,
    input logic [BYTE_W-1:0] in_byte,
    input logic [1:0]        mode,
    input logic              neg_scr_en,
    input logic              out_valid,
    input logic              out_ctrl,
    input logic [BYTE_W-1:0] out_byte,
    input logic [LFSR_W-1:0] lfsr_q
);
    // R1: valid follows input one cycle later
    a_r1_valid_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r11_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(lfsr_q)));
    // R2: control symbols pass unchanged
    a_r2_ctrl_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl) |=> (out_ctrl && out_byte == $past(in_byte)));
    a_r3_align_seed: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl && in_byte == ALIGN_CODE) |=> (lfsr_q == SEED));
    a_r4_skip_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ctrl && in_byte == SKIP_CODE) |=> $stable(lfsr_q));
    a_r5_force_off: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ctrl && mode == 2'b01) |=> (out_byte == $past(in_byte)));
    a_r7_follow_off: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ctrl && (mode == 2'b00 || mode == 2'b11) && !neg_scr_en)
        |=> (out_byte == $past(in_byte)));
    a_r12_data_no_seed: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ctrl && lfsr_q != 16'h0000) |=> !$stable(lfsr_q));
endmodule

bind lnk_descrambler lnk_descrambler_chk #(
    .SEED       (SEED),
    .ALIGN_CODE (ALIGN_CODE),
    .SKIP_CODE  (SKIP_CODE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ctrl    (in_ctrl),
    .in_byte    (in_byte),
    .mode       (mode),
    .neg_scr_en (neg_scr_en),
    .out_valid  (out_valid),
    .out_ctrl   (out_ctrl),
    .out_byte   (out_byte),
    .lfsr_q     (lfsr_q)
);

// File: tb/tb_lnk_descrambler.sv
`timescale 1ns/1ps
module tb_lnk_descrambler;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_ctrl, neg_scr_en, variant_sel;
    logic [7:0] in_byte;
    logic [1:0] mode;
    logic       out_valid, out_ctrl;
    logic [7:0] out_byte;

    int total = 0;
    int bad   = 0;
    logic [15:0] ms;  // bench model of register

    always #2.5 clk = ~clk;

    lnk_descrambler dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_byte(in_byte), .mode(mode), .neg_scr_en(neg_scr_en),
        .variant_sel(variant_sel), .out_valid(out_valid),
        .out_ctrl(out_ctrl), .out_byte(out_byte)
    );

    // {ctrl, byte, mode, neg, variant}
    localparam int NV = 16;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {1'b1, 8'hBC, 2'b00, 1'b1, 1'b0},
        {1'b0, 8'h00, 2'b00, 1'b1, 1'b0},
        {1'b0, 8'h5A, 2'b00, 1'b1, 1'b0},
        {1'b1, 8'h1C, 2'b00, 1'b1, 1'b0},
        {1'b0, 8'hA5, 2'b00, 1'b1, 1'b1},
        {1'b1, 8'hF7, 2'b10, 1'b0, 1'b0},
        {1'b0, 8'h3C, 2'b10, 1'b0, 1'b0},
        {1'b0, 8'h3C, 2'b01, 1'b1, 1'b0},
        {1'b0, 8'hFF, 2'b11, 1'b1, 1'b1},
        {1'b0, 8'h81, 2'b11, 1'b0, 1'b0},
        {1'b1, 8'h1C, 2'b01, 1'b0, 1'b1},
        {1'b1, 8'h1C, 2'b10, 1'b1, 1'b1},
        {1'b0, 8'h0F, 2'b10, 1'b0, 1'b1},
        {1'b1, 8'hBC, 2'b10, 1'b0, 1'b0},
        {1'b0, 8'hC3, 2'b00, 1'b0, 1'b0},
        {1'b0, 8'h77, 2'b10, 1'b1, 1'b0}
    };

    function automatic logic [7:0] model_key(input logic [15:0] s);
        logic [15:0] t = s;
        logic [7:0]  k;
        for (int i = 0; i < 8; i++) begin
            k[i] = t[15];
            t = {t[14:0], 1'b0} ^ (t[15] ? 16'h0039 : 16'h0000);
        end
        return k;
    endfunction

    function automatic logic [15:0] model_next(input logic [15:0] s);
        logic [15:0] t = s;
        for (int i = 0; i < 8; i++)
            t = {t[14:0], 1'b0} ^ (t[15] ? 16'h0039 : 16'h0000);
        return t;
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (valid,ctrl,byte)", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge
    task automatic send(input string req, input logic c, input logic [7:0] b,
                        input logic [1:0] m, input logic n, input logic v,
                        input bit use_fixed, input logic [7:0] fixed_exp);
        logic [7:0] k, kr, e;
        logic       en;
        in_valid = 1'b1; in_ctrl = c; in_byte = b;
        mode = m; neg_scr_en = n; variant_sel = v;
        k = model_key(ms);
        for (int i = 0; i < 8; i++) kr[i] = v ? k[7-i] : k[i];
        en = (m == 2'b10) || (m != 2'b01 && n);
        e  = (c || !en) ? b : (b ^ kr);
        if (use_fixed) e = fixed_exp;
        if (c && b == 8'hBC)      ms = 16'hFFFF;
        else if (c && b == 8'h1C) ms = ms;
        else                      ms = model_next(ms);
        @(posedge clk);
        @(negedge clk);
        chk(req, {out_valid, out_ctrl, out_byte}, {1'b1, c, e});
    endtask

    task automatic idle(input string req);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL %s: actual out_valid=%b expected=0", req, out_valid);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_ctrl = 1'b0; in_byte = 8'h00;
        mode = 2'b00; neg_scr_en = 1'b0; variant_sel = 1'b0;
        ms = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: outputs zero in reset
        chk("R10 reset", {out_valid, out_ctrl, out_byte}, 10'h000);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 after reset", {out_valid, out_ctrl, out_byte}, 10'h000);

        // R10 + R9: register seeded by reset, first key 0xFF
        send("R10 seed key", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'hFF);

        // table walk (R1 R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            logic [12:0] w = VEC[i];
            string r;
            if (w[12]) r = (w[11:4] == 8'hBC) ? "R3 align" : "R2 ctrl pass";
            else if (w[3:2] == 2'b01) r = "R5 force off";
            else if (w[3:2] == 2'b10) r = "R6 force on";
            else r = "R7/R8 follow";
            send(r, w[12], w[11:4], w[3:2], w[1], w[0], 1'b0, 8'h00);
        end

        // R3/R9 fixed keys after alignment: 0xFF then 0x17
        send("R3 align", 1'b1, 8'hBC, 2'b00, 1'b1, 1'b0, 1'b0, 8'h00);
        send("R3 key0", 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b1, 8'hFF);
        send("R9 key1", 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b1, 8'h17);
        // R8 ordering B on second key: 0xE8
        send("R3 align", 1'b1, 8'hBC, 2'b00, 1'b1, 1'b1, 1'b0, 8'h00);
        send("R8 B key0", 1'b0, 8'h00, 2'b00, 1'b1, 1'b1, 1'b1, 8'hFF);
        send("R8 B key1", 1'b0, 8'h00, 2'b00, 1'b1, 1'b1, 1'b1, 8'hE8);

        // R4 skip between data bytes keeps key 0x17
        send("R3 align", 1'b1, 8'hBC, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00);
        send("R4 pre", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'hFF);
        send("R4 skip", 1'b1, 8'h1C, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00);
        send("R4 after skip", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'h17);

        // R4: forced-off data still advances
        send("R3 align", 1'b1, 8'hBC, 2'b01, 1'b0, 1'b0, 1'b0, 8'h00);
        send("R5 off", 1'b0, 8'h42, 2'b01, 1'b0, 1'b0, 1'b1, 8'h42);
        send("R4 advance", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'h17);

        // R11 idle gaps keep key
        send("R3 align", 1'b1, 8'hBC, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00);
        send("R11 pre", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'hFF);
        idle("R11 idle");
        idle("R11 idle");
        send("R11 after idle", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'h17);

        // R12 data byte equal to align code is data
        send("R3 align", 1'b1, 8'hBC, 2'b10, 1'b0, 1'b0, 1'b0, 8'h00);
        send("R12 data BC", 1'b0, 8'hBC, 2'b10, 1'b0, 1'b0, 1'b1, 8'h43);
        send("R12 next", 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 8'h17);

        // R7 follow with negotiation off, alt code 11
        send("R7 follow off", 1'b0, 8'h99, 2'b11, 1'b0, 1'b0, 1'b1, 8'h99);
        send("R7 follow on", 1'b0, 8'h99, 2'b00, 1'b1, 1'b0, 1'b0, 8'h00);

        idle("R1 valid drop");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule